// File: doc/BRIEF.md
# Black level clamp loop controller

This block closes the digital half of an optical-black clamp loop in a sensor front end. On every pixel clock it takes a converter sample and, while the black-window qualifier is high, adds the signed difference between that sample and a programmed black-level target to an accumulator. The target is an 8-bit code. For 10-bit converter data it counts quarter LSBs, and for 12-bit data it counts whole LSBs. The converter width is a build parameter.

When the black window closes, the accumulated error is divided by a programmable power of two. That step is subtracted from a saturating correction word, which feeds an external offset DAC. The correction then holds until the next window closes. The right shift sets the loop bandwidth, and one update per window gives the first-order low-pass response.

When the loop is switched off, the accumulator is emptied and the correction word follows the target code directly. The target then acts as a fixed programmable offset. When the loop is switched back on, it starts from that offset.

Top module: `blc_loop`

## Requirements
- R1: While reset is held low at a clock edge, the correction output becomes mid-scale, 2^(CORR_W-1), and the accumulator and sample count are cleared.
- R2: With ADC_W = 10, the target counts quarter LSBs, so each in-window sample adds (4 * sample - target) to the accumulator.
- R3: With ADC_W = 12, the target counts whole LSBs, so each in-window sample adds (sample - target) to the accumulator.
- R4: Samples taken while the window input is low have no effect on the accumulator or on the correction output.
- R5: On the first clock edge at which the window input is sampled low after being high (loop enabled), the correction becomes old value minus floor(accumulator / 2^gain_shift) and the accumulator clears. The correction holds at every other edge while the loop is enabled.
- R6: The correction word saturates at 0 and at 2^CORR_W - 1 and never wraps.
- R7: Only the first MAX_WIN samples of a window are accumulated, and later samples in the same window are ignored.
- R8: While loop_en is low at a clock edge, the correction becomes the target code zero-extended, and the accumulator and sample count clear. After loop_en returns high, updates start from that value.
- R9: A window of only two pixels is accumulated and applied like any longer window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adc_data | input | ADC_W | Converter sample, straight binary |
| ob_win | input | 1 | High during the optical-black window |
| loop_en | input | 1 | 1 = loop running, 0 = static offset from target_code |
| target_code | input | 8 | Black-level target (quarter LSB at ADC_W=10, LSB at ADC_W=12) |
| gain_shift | input | SHIFT_W | Right shift applied to the window sum |
| corr_code | output | CORR_W | Offset correction word for the offset DAC |

## Verification
The bench builds two copies side by side from the same stimulus. One uses ADC_W = 10 and the other ADC_W = 12, so both target scalings are checked against one stream of samples. Both copies use CORR_W = 9, which narrows the correction range so that a few full-scale windows drive it into either rail. They also use MAX_WIN = 8, so a 20-pixel window runs well past the sample cap. SHIFT_W = 3 lets shifts from 0 to 5 be swept, including negative window sums that must round toward minus infinity.

// File: rtl/blc_pkg.sv
// Shared helpers for the black level clamp loop.
// Assumes converter widths of 10 or 12 bits; narrower data is treated as the 10-bit case.
package blc_pkg;

    // Fractional target bits: quarter-LSB steps for 10-bit data, whole LSBs for 12-bit.
    function automatic int tgt_frac(input int adc_w);
        return (adc_w <= 10) ? 2 : 0;
    endfunction

endpackage

// File: rtl/blc_err.sv
// Error former: scales the converter sample into target units and subtracts the target.
// Assumes ERR_W = ADC_W + FRAC + 1, which leaves room for the sign bit.
module blc_err #(
    parameter int ADC_W = 12,
    parameter int FRAC  = 0,
    parameter int ERR_W = 13
) (
    input  logic [ADC_W-1:0]        adc_i,
    input  logic [7:0]              target_i,
    output logic signed [ERR_W-1:0] err_o
);
    localparam int SC_W = ADC_W + FRAC;

    logic [SC_W-1:0] scaled;

    generate
        if (FRAC > 0) begin : g_quarter
            assign scaled = {adc_i, {FRAC{1'b0}}};
        end else begin : g_whole
            assign scaled = adc_i;
        end
    endgenerate

    assign err_o = $signed({1'b0, scaled}) - $signed({{(ERR_W-8){1'b0}}, target_i});

endmodule

// File: rtl/blc_accum.sv
// Window accumulator: sums at most MAX_WIN errors per black window and flags the window end.
// Assumes ACC_W = ERR_W + CNT_W, so MAX_WIN full-scale errors cannot overflow the sum.
module blc_accum #(
    parameter int MAX_WIN = 64,
    parameter int ERR_W   = 13,
    parameter int CNT_W   = 7,
    parameter int ACC_W   = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    loop_en,
    input  logic                    ob_win,
    input  logic signed [ERR_W-1:0] err_i,
    output logic signed [ACC_W-1:0] acc_o,
    output logic [CNT_W-1:0]        cnt_o,
    output logic                    end_o
);
    logic                    ob_prev;
    logic signed [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0]        cnt_q;
    logic                    take;

    assign take  = loop_en && ob_win && (cnt_q < CNT_W'(MAX_WIN));
    assign end_o = loop_en && ob_prev && !ob_win;
    assign acc_o = acc_q;
    assign cnt_o = cnt_q;

    // Remember the previous window level so the falling edge can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) ob_prev <= 1'b0;
        else        ob_prev <= ob_win;
    end

    // Accumulate capped in-window errors; clear when the loop is off or the window ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !loop_en || end_o) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            acc_q <= acc_q + {{CNT_W{err_i[ERR_W-1]}}, err_i};
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/blc_corr.sv
// Correction register: applies the shifted window sum with saturation, or loads the static offset.
// Assumes CORR_W > 8 so that the 8-bit target fits as a static offset.
module blc_corr #(
    parameter int CORR_W  = 10,
    parameter int ACC_W   = 20,
    parameter int SHIFT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    loop_en,
    input  logic                    end_i,
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic [SHIFT_W-1:0]      shift_i,
    input  logic [7:0]              target_i,
    output logic [CORR_W-1:0]       corr_o
);
    localparam int SW = ((ACC_W > CORR_W) ? ACC_W : CORR_W) + 2;
    localparam logic [CORR_W-1:0] MID  = {1'b1, {(CORR_W-1){1'b0}}};
    localparam logic [CORR_W-1:0] CMAX = {CORR_W{1'b1}};

    logic [CORR_W-1:0]       corr_q;
    logic signed [ACC_W-1:0] step;
    logic signed [SW-1:0]    nxt;
    logic [CORR_W-1:0]       sat;

    assign step = acc_i >>> shift_i;
    assign nxt  = $signed({{(SW-CORR_W){1'b0}}, corr_q})
                - $signed({{(SW-ACC_W){step[ACC_W-1]}}, step});

    // Clip the candidate correction to the legal code range.
    always_comb begin
        if (nxt < 0)
            sat = '0;
        else if (nxt > $signed({{(SW-CORR_W){1'b0}}, CMAX}))
            sat = CMAX;
        else
            sat = nxt[CORR_W-1:0];
    end

    // Hold, apply the window update, or follow the static offset.
    always_ff @(posedge clk) begin
        if (!rst_n)       corr_q <= MID;
        else if (!loop_en) corr_q <= {{(CORR_W-8){1'b0}}, target_i};
        else if (end_i)   corr_q <= sat;
    end

    assign corr_o = corr_q;

endmodule

// File: rtl/blc_loop.sv
// Black level clamp loop top: error former, window accumulator and correction register.
// Assumes ob_win and loop_en are synchronous to clk and adc_data is valid on every cycle.
module blc_loop #(
    parameter int ADC_W   = 12,
    parameter int CORR_W  = 10,
    parameter int MAX_WIN = 64,
    parameter int SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADC_W-1:0]   adc_data,
    input  logic               ob_win,
    input  logic               loop_en,
    input  logic [7:0]         target_code,
    input  logic [SHIFT_W-1:0] gain_shift,
    output logic [CORR_W-1:0]  corr_code
);
    localparam int FRAC  = blc_pkg::tgt_frac(ADC_W);
    localparam int ERR_W = ADC_W + FRAC + 1;
    localparam int CNT_W = $clog2(MAX_WIN + 1);
    localparam int ACC_W = ERR_W + CNT_W;

    logic signed [ERR_W-1:0] err_w;
    logic signed [ACC_W-1:0] acc_w;
    logic [CNT_W-1:0]        cnt_w;
    logic                    end_w;

    blc_err #(.ADC_W(ADC_W), .FRAC(FRAC), .ERR_W(ERR_W)) u_err (
        .adc_i    (adc_data),
        .target_i (target_code),
        .err_o    (err_w)
    );

    blc_accum #(.MAX_WIN(MAX_WIN), .ERR_W(ERR_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .loop_en (loop_en),
        .ob_win  (ob_win),
        .err_i   (err_w),
        .acc_o   (acc_w),
        .cnt_o   (cnt_w),
        .end_o   (end_w)
    );

    blc_corr #(.CORR_W(CORR_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_corr (
        .clk      (clk),
        .rst_n    (rst_n),
        .loop_en  (loop_en),
        .end_i    (end_w),
        .acc_i    (acc_w),
        .shift_i  (gain_shift),
        .target_i (target_code),
        .corr_o   (corr_code)
    );

endmodule

// File: rtl/blc_loop_chk.sv
// Protocol checker for blc_loop, attached through bind.
// Assumes the accumulator and count nets of the top are connected to acc and cnt.
module blc_loop_chk #(
    parameter int CORR_W  = 10,
    parameter int ACC_W   = 20,
    parameter int CNT_W   = 7,
    parameter int MAX_WIN = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    loop_en,
    input logic                    ob_win,
    input logic [7:0]              target_code,
    input logic [CORR_W-1:0]       corr_code,
    input logic signed [ACC_W-1:0] acc,
    input logic [CNT_W-1:0]        cnt
);
    localparam logic [CORR_W-1:0] MID = {1'b1, {(CORR_W-1){1'b0}}};

    logic rst_d;
    logic ob_d;

    // Delayed reset level marks the first cycle after reset.
    always_ff @(posedge clk) rst_d <= rst_n;

    // Delayed window level, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ob_d <= 1'b0;
        else        ob_d <= ob_win;
    end

    assert_reset_mid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_d |-> corr_code == MID);

    assert_idle_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && !ob_win) |=> (acc == '0 || $stable(acc)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && !(ob_d && !ob_win)) |=> $stable(corr_code));

    assert_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && ob_win && cnt == CNT_W'(MAX_WIN)) |=> (acc == '0 || $stable(acc)));

    assert_static_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> corr_code == {{(CORR_W-8){1'b0}}, $past(target_code)});

endmodule

bind blc_loop blc_loop_chk #(
    .CORR_W(CORR_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .MAX_WIN(MAX_WIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .loop_en     (loop_en),
    .ob_win      (ob_win),
    .target_code (target_code),
    .corr_code   (corr_code),
    .acc         (acc_w),
    .cnt         (cnt_w)
);

// File: tb/blc_loop_tb.sv
// Bench: two builds (10-bit and 12-bit data) compared every cycle against a behavioural model.
module blc_loop_tb;
    localparam int CORR_W = 9;
    localparam int MAXW   = 8;
    localparam int CMAX   = (1 << CORR_W) - 1;
    localparam int MID    = 1 << (CORR_W - 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [11:0] adc = '0;
    logic       ob = 1'b0;
    logic       en = 1'b1;
    logic [7:0] tgt = 8'd0;
    logic [2:0] sh = 3'd0;
    logic [CORR_W-1:0] corr10, corr12;

    int unsigned seed = 32'h1234_5678;
    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    int m_corr[2];
    int m_acc[2];
    int m_cnt[2];
    int m_obp;

    always #2.5 clk = ~clk;

    blc_loop #(.ADC_W(10), .CORR_W(CORR_W), .MAX_WIN(MAXW), .SHIFT_W(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .adc_data(adc[9:0]), .ob_win(ob), .loop_en(en),
        .target_code(tgt), .gain_shift(sh), .corr_code(corr10)
    );

    blc_loop #(.ADC_W(12), .CORR_W(CORR_W), .MAX_WIN(MAXW), .SHIFT_W(3)) u_dut12 (
        .clk(clk), .rst_n(rst_n), .adc_data(adc), .ob_win(ob), .loop_en(en),
        .target_code(tgt), .gain_shift(sh), .corr_code(corr12)
    );

    // Behavioural reference: index 0 is 10-bit data (quarter-LSB target), index 1 is 12-bit.
    always @(posedge clk) begin
        int err;
        int nv;
        for (int k = 0; k < 2; k++) begin
            err = (k == 0) ? (4 * int'(adc[9:0]) - int'(tgt)) : (int'(adc) - int'(tgt));
            if (!rst_n) begin
                m_corr[k] = MID; m_acc[k] = 0; m_cnt[k] = 0;
            end else if (!en) begin
                m_corr[k] = int'(tgt); m_acc[k] = 0; m_cnt[k] = 0;
            end else if (m_obp == 1 && !ob) begin
                nv = m_corr[k] - (m_acc[k] >>> int'(sh));
                if (nv < 0) nv = 0;
                if (nv > CMAX) nv = CMAX;
                m_corr[k] = nv; m_acc[k] = 0; m_cnt[k] = 0;
            end else if (ob && m_cnt[k] < MAXW) begin
                m_acc[k] += err; m_cnt[k] += 1;
            end
        end
        m_obp = (!rst_n) ? 0 : int'(ob);
    end

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed >> 16);
    endfunction

    // Advance one clock and compare both builds at the falling edge.
    task automatic tick();
        @(negedge clk);
        if (cmp_on) begin
            n_cmp += 2;
            if (int'(corr10) != m_corr[0]) begin
                n_bad++;
                $display("FAIL %s 10-bit corr actual %0d expected %0d t=%0t", cur_req, corr10, m_corr[0], $time);
            end
            if (int'(corr12) != m_corr[1]) begin
                n_bad++;
                $display("FAIL %s 12-bit corr actual %0d expected %0d t=%0t", cur_req, corr12, m_corr[1], $time);
            end
        end
    endtask

    // One black window of n pixels near black, then a gap of noisy pixels (R4 stimulus).
    task automatic run_win(input int n, input int base, input int gap);
        for (int i = 0; i < n; i++) begin
            ob = 1'b1;
            adc = 12'(base + (rnd() & 15));
            tick();
        end
        ob = 1'b0;
        for (int i = 0; i < gap; i++) begin
            adc = 12'(rnd());
            tick();
        end
    endtask

    initial begin
        m_obp = 0;
        for (int k = 0; k < 2; k++) begin m_corr[k] = MID; m_acc[k] = 0; m_cnt[k] = 0; end
        @(posedge clk);
        cmp_on = 1'b1;
        cur_req = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (3) tick();

        cur_req = "R2_R3";
        tgt = 8'd40; sh = 3'd3;
        for (int w = 0; w < 6; w++) run_win(6, 8 + w, 4);
        tgt = 8'd200; sh = 3'd2;
        for (int w = 0; w < 4; w++) run_win(5, 40 + 5 * w, 3);

        cur_req = "R4";
        adc = 12'hFFF; ob = 1'b0;
        repeat (12) begin adc = 12'(rnd()); tick(); end

        cur_req = "R5";
        tgt = 8'd60;
        for (int s = 0; s < 6; s++) begin
            sh = 3'(s);
            run_win(4, 5, 2);
            run_win(4, 25, 2);
        end

        cur_req = "R9";
        sh = 3'd0;
        for (int w = 0; w < 4; w++) run_win(2, 10 + 3 * w, 3);

        cur_req = "R7";
        sh = 3'd1;
        for (int w = 0; w < 3; w++) run_win(20, 12, 3);

        cur_req = "R6";
        sh = 3'd0; tgt = 8'd0;
        for (int w = 0; w < 3; w++) run_win(8, 1008, 2);
        tgt = 8'd255;
        for (int w = 0; w < 4; w++) run_win(8, 0, 2);

        cur_req = "R8";
        en = 1'b0; tgt = 8'd77;
        repeat (3) tick();
        ob = 1'b1; tgt = 8'd150; adc = 12'd900;
        repeat (3) tick();
        ob = 1'b0;
        repeat (2) tick();
        en = 1'b1; sh = 3'd2; tgt = 8'd20;
        run_win(6, 3, 3);
        ob = 1'b1; adc = 12'd500;
        repeat (3) tick();
        en = 1'b0;
        tick();
        ob = 1'b0; en = 1'b1;
        repeat (3) tick();
        run_win(3, 30, 3);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog %s actual running expected finished", cur_req);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule